// File: doc/BRIEF.md
# Serial memory page write engine

This block sits behind the serial front end of a byte-wide nonvolatile memory. Once a write command and its start address have been decoded, it collects the data bytes that follow into a page buffer. Each byte is stored at the current in-page index. The upper address bits stay fixed for the whole command. The in-page index advances by one per byte and wraps at the page boundary, so a byte sent after a full page replaces the byte that used that index before it.

When chip select rises, the block checks whether the command ended cleanly. A clean end has no partial byte pending and at least one complete data byte received. On a clean end the block enters a self-timed programming cycle. There is no erase phase. The busy flag is high for a fixed number of clocks. At the start of that cycle the block walks the buffer once and drives the array write port for each byte that was received, unless the protection logic refuses that address. On the last busy clock it pulses a completion flag, which the surrounding logic uses to clear its write enable latch. If the end is not clean, the command is dropped and nothing is programmed. While the cycle runs, all command inputs are ignored.

Top module: `page_write_engine`

## Requirements
- R1: A data byte received during collection is stored at in-page index i, and i then becomes (i+1) mod PAGE_BYTES. The programming cycle writes each stored byte to array address {upper start-address bits, i}. The upper bits are the address bits above the low log2(PAGE_BYTES) bits.
- R2: When more bytes than PAGE_BYTES arrive, the index wraps. The last byte received at an index is the one that is programmed.
- R3: A `cs_rise` pulse during collection starts the programming cycle only when two conditions hold: the count of `bit_tick` pulses is a multiple of 8, and at least one `byte_valid` has been seen. In that case `busy` is 1 from the next clock.
- R4: A `cs_rise` that comes mid-byte, or before any complete byte, ends the command without raising `busy` and without any array write.
- R5: `busy` stays high for exactly CYCLE_CLKS consecutive clocks.
- R6: `done` is high for exactly one clock, which is the last clock in which `busy` is high.
- R7: Each received index is written exactly once, during the first PAGE_BYTES busy clocks. Indices that received no byte are never written. `mem_we` is only ever high while `busy` is high.
- R8: Whenever `wr_allow` is low for the address on `mem_addr`, `mem_we` stays low for that address.
- R9: `wr_start`, `bit_tick`, `byte_valid` and `cs_rise` have no effect while `busy` is high. They cause no extra busy time and no extra writes.
- R10: After reset, `busy`, `done` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Pulse: a write command and its address have been decoded |
| start_addr | input | ADDR_W | First byte address of the command |
| bit_tick | input | 1 | Pulse per serial data bit received after the address |
| byte_valid | input | 1 | Pulse with the eighth bit of each data byte |
| byte_data | input | 8 | Assembled data byte, valid with `byte_valid` |
| cs_rise | input | 1 | Pulse: chip select was deasserted |
| wr_allow | input | 1 | Protection verdict for the current `mem_addr` |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | Last clock of the programming cycle |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The first clock edge after `cs_rise` decides the outcome. On a clean end, `busy` is high from that edge for CYCLE_CLKS clocks. The buffer walk occupies busy clocks 1 to PAGE_BYTES, with at most one write per clock, and `done` falls on busy clock CYCLE_CLKS. The bench drives inputs on falling edges and tallies `busy`, `done` and every write at rising edges. It waits CYCLE_CLKS+10 clocks after `cs_rise`, so every due event has happened before the totals are compared with counts worked out from the offset, length, trailing bits and protection setting of each run.

// File: rtl/page_write_engine.sv
module page_write_engine #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              bit_tick,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              wr_allow,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int UW = ADDR_W - IW;
  localparam int TW = $clog2(CYCLE_CLKS);
  localparam logic [TW-1:0] PAGE_T = TW'(PAGE_BYTES);
  localparam logic [TW-1:0] LAST_T = TW'(CYCLE_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_BUSY} state_t;

  state_t                st;
  logic [UW-1:0]         base;
  logic [IW-1:0]         idx;
  logic [2:0]            bitcnt;
  logic                  got;
  logic [PAGE_BYTES-1:0] vmask;
  logic [TW-1:0]         timer;
  logic [7:0]            pbuf [PAGE_BYTES];

  wire [IW-1:0] sweep    = timer[IW-1:0];
  wire          in_sweep = (st == S_BUSY) && (timer < PAGE_T);
  wire          take     = (st == S_FILL) && !cs_rise && byte_valid;

  assign busy      = (st == S_BUSY);
  assign done      = busy && (timer == LAST_T);
  assign mem_addr  = {base, sweep};
  assign mem_wdata = pbuf[sweep];
  assign mem_we    = in_sweep && vmask[sweep] && wr_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base   <= '0;
      idx    <= '0;
      bitcnt <= '0;
      got    <= 1'b0;
      vmask  <= '0;
      timer  <= '0;
    end else begin
      case (st)
        S_IDLE: if (wr_start) begin
          st     <= S_FILL;
          base   <= start_addr[ADDR_W-1:IW];
          idx    <= start_addr[IW-1:0];
          bitcnt <= '0;
          got    <= 1'b0;
          vmask  <= '0;
        end
        S_FILL: begin
          if (cs_rise) begin
            if (bitcnt == 3'd0 && got) begin
              st    <= S_BUSY;
              timer <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            if (bit_tick) bitcnt <= bitcnt + 3'd1;
            if (byte_valid) begin
              vmask[idx] <= 1'b1;
              idx        <= idx + IW'(1);
              got        <= 1'b1;
            end
          end
        end
        S_BUSY: if (timer == LAST_T) st <= S_IDLE;
                else timer <= timer + TW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[idx] <= byte_data;
  end

  a_r3_start_from_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  a_r4_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && st == S_FILL && (bitcnt != 3'd0 || !got)) |=> !busy);
  a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r7_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  a_r8_allow: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_allow);
  a_r1_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:IW]));
endmodule

// File: tb/page_write_engine_bench.sv
module page_write_engine_bench;
  localparam int AW  = 16;
  localparam int PG  = 128;
  localparam int CYC = 140;

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, bit_tick = 0, byte_valid = 0, cs_rise = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic busy, done, mem_we, wr_allow;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic prot_on = 0;

  int total = 0, bad = 0;
  int got_pg [PG];
  int wcnt, bcnt, dcnt, badaddr, exp_base;

  assign wr_allow = prot_on ? ~mem_addr[6] : 1'b1;

  page_write_engine #(.ADDR_W(AW), .PAGE_BYTES(PG), .CYCLE_CLKS(CYC)) u_page_write_engine (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .start_addr(start_addr),
    .bit_tick(bit_tick), .byte_valid(byte_valid), .byte_data(byte_data),
    .cs_rise(cs_rise), .wr_allow(wr_allow), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (busy) bcnt++;
    if (done) dcnt++;
    if (mem_we) begin
      got_pg[mem_addr[6:0]] = mem_wdata;
      wcnt++;
      if (int'(mem_addr[15:7]) != exp_base) badaddr++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      bit_tick = 1;
      byte_valid = (b == 7);
      byte_data = d;
    end
    @(negedge clk);
    bit_tick = 0;
    byte_valid = 0;
  endtask

  function automatic logic [7:0] dval(input int k, input int len, input int off);
    return 8'((k * 7 + len + off) & 255);
  endfunction

  task automatic run(input int off, input int len, input int extra, input bit prot, input bit poke);
    int upper, exp_pg [PG], ew, ok;
    upper = (off * 3 + len + 5) & 511;
    for (int i = 0; i < PG; i++) begin got_pg[i] = -1; exp_pg[i] = -1; end
    wcnt = 0; bcnt = 0; dcnt = 0; badaddr = 0; exp_base = upper;
    prot_on = prot;
    @(negedge clk);
    wr_start = 1; start_addr = AW'((upper << 7) | off);
    @(negedge clk);
    wr_start = 0;
    for (int k = 0; k < len; k++) send_byte(dval(k, len, off));
    for (int e = 0; e < extra; e++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
    @(negedge clk); cs_rise = 1;
    @(negedge clk); cs_rise = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      wr_start = 1; start_addr = '0;
      @(negedge clk); wr_start = 0;
      send_byte(8'hEE);
      @(negedge clk); cs_rise = 1;
      @(negedge clk); cs_rise = 0;
    end
    repeat (CYC + 10) @(negedge clk);
    ok = (len > 0 && extra == 0);
    ew = 0;
    if (ok)
      for (int k = 0; k < len; k++) exp_pg[(off + k) % PG] = dval(k, len, off);
    if (prot) for (int i = 64; i < PG; i++) exp_pg[i] = -1;
    for (int i = 0; i < PG; i++) if (exp_pg[i] >= 0) ew++;
    chk(poke ? "R9 busy length" : (ok ? "R3/R5 busy length" : "R4 busy length"), bcnt, ok ? CYC : 0);
    chk("R6 done pulses", dcnt, ok ? 1 : 0);
    chk(prot ? "R8 write count" : "R7 write count", wcnt, ew);
    chk("R1 upper address", badaddr, 0);
    begin
      int mism = 0;
      for (int i = 0; i < PG; i++) if (got_pg[i] != exp_pg[i]) mism++;
      chk(len > PG ? "R2 page content" : "R1 page content", mism, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int offs [4] = '{0, 1, 85, 127};
    int lens [6] = '{1, 2, 63, 128, 129, 150};
    repeat (3) @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 mem_we", int'(mem_we), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    foreach (offs[a]) foreach (lens[b]) run(offs[a], lens[b], 0, 0, 0);
    run(0, 128, 0, 1, 0);
    run(100, 40, 0, 1, 0);
    run(10, 3, 3, 0, 0);
    run(10, 2, 7, 0, 0);
    run(10, 0, 0, 0, 0);
    run(10, 0, 4, 0, 0);
    run(20, 5, 0, 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule